// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block turns host IO and memory requests into downstream configuration read and write requests. It offers two ways in. The first is an index/data pair of 32-bit IO registers. A write to the index port stores a target address locally. A later read or write of the data port is then sent out as a configuration access to the bus, device, function and dword register held in that index. The second is a memory window of 256 MiB whose base can be moved. A memory access that lands inside the window carries its target in the address offset.

The host side uses a valid/ready handshake. The host holds `req_valid` and the request fields until `req_ready` pulses for one cycle, and read data is valid in that same cycle. A request that needs a configuration access is held until the downstream side reports completion with `cfg_ready`. All other requests finish locally. A sideband strobe loads the window's enable and base.

Top module: `cfg_access_bridge`

## Requirements
- R1: A write to IO address 0xCF8 stores the write data in the index register and produces no configuration request (`cfg_valid` stays low).
- R2: A read of IO address 0xCF8 returns the stored index with bits 30:24 and bits 1:0 forced to zero.
- R3: When index bit 31 is set, a read of IO address 0xCFC issues a configuration read with bus = index[23:16], device = index[15:11], function = index[10:8] and register = index[7:2] (upper register bits zero). The completion data is returned to the host.
- R4: When index bit 31 is set, a write to IO address 0xCFC issues a configuration write with the same target fields and carries the host write data unchanged.
- R5: When index bit 31 is clear, an access to 0xCFC issues no configuration request. A read returns 0xFFFFFFFF and a write is dropped.
- R6: With the window enabled, a memory access whose address bits 31:28 equal the programmed base issues a configuration request with bus = addr[27:20], device = addr[19:15], function = addr[14:12] and register = addr[11:2].
- R7: A memory access outside the window, any memory access while the window is disabled, and an IO access to any other address issue no configuration request. Such a read returns 0xFFFFFFFF.
- R8: While `cfg_valid` is high and `cfg_ready` is low, the request fields hold steady. `req_ready` pulses in the cycle after the `cfg_valid`/`cfg_ready` handshake, carrying `cfg_rdata` for reads.
- R9: A request completed locally raises `req_ready` for exactly one cycle, in the cycle after the edge that accepts it.
- R10: Reset clears the index register to zero and disables the memory window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_set | input | 1 | Strobe that loads window enable and base |
| win_enable | input | 1 | Window enable value loaded by `win_set` |
| win_base | input | 4 | Window base (address bits 31:28) loaded by `win_set` |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Host request complete, one-cycle pulse |
| req_is_io | input | 1 | 1 = IO space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host address |
| req_wdata | input | 32 | Host write data |
| req_rdata | output | 32 | Read data, valid with `req_ready` |
| cfg_valid | output | 1 | Configuration request present |
| cfg_ready | input | 1 | Downstream completion |
| cfg_write | output | 1 | 1 = configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 10 | Target dword register number |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_rdata | input | 32 | Configuration read data, valid with `cfg_ready` |

## Verification
A locally completed request raises `req_ready` one cycle after the accepting edge. A configuration request raises it two cycles after acceptance plus the number of cycles the downstream model waits before `cfg_ready`. The bench drives inputs and samples outputs on falling edges and counts falling edges from the request to `req_ready`. It compares that count against 1, or against 2 plus the model's configured wait, which is varied from 0 to 2 across the sweep. The downstream model records the target fields in the cycle it completes a request and tallies the requests it sees, so a request that should not exist appears as a nonzero tally.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
   localparam int BUS_W = 8;
   localparam int DEV_W = 5;
   localparam int FN_W  = 3;
   localparam int REG_W = 10;

   // index register layout
   localparam int IX_EN     = 31;
   localparam int IX_BUS_LO = 16;
   localparam int IX_DEV_LO = 11;
   localparam int IX_FN_LO  = 8;
   localparam int IX_REG_LO = 2;
   localparam int IX_REG_W  = 6;
   localparam logic [31:0] IX_READ_MASK = 32'h80FF_FFFC;

   // window offset layout
   localparam int WN_BUS_LO = 20;
   localparam int WN_DEV_LO = 15;
   localparam int WN_FN_LO  = 12;
   localparam int WN_REG_LO = 2;

   typedef struct packed {
      logic [BUS_W-1:0] bus;
      logic [DEV_W-1:0] dev;
      logic [FN_W-1:0]  fn;
      logic [REG_W-1:0] rg;
   } cfg_target_t;

   typedef enum logic [1:0] {
      K_INDEX = 2'd0,
      K_CFG   = 2'd1,
      K_MISS  = 2'd2
   } acc_kind_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_RESP  = 2'd2
   } bridge_state_t;
endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg #(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] READ_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] idx_q,
   output logic [DATA_W-1:0] idx_view
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     idx_q <= '0;
      else if (wr_en) idx_q <= wr_data;
   end

   assign idx_view = idx_q & READ_MASK;
endmodule

// File: rtl/cfgx_window_reg.sv
module cfgx_window_reg #(
   parameter int BASE_W     = 4,
   parameter bit HAS_WINDOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set,
   input  logic              enable_in,
   input  logic [BASE_W-1:0] base_in,
   output logic              en_q,
   output logic [BASE_W-1:0] base_q
);
   generate
      if (HAS_WINDOW) begin : g_window
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               base_q <= '0;
            end else if (set) begin
               en_q   <= enable_in;
               base_q <= base_in;
            end
         end
      end else begin : g_no_window
         logic unused_in;
         assign unused_in = &{clk, rst_n, set, enable_in, base_in};
         assign en_q   = 1'b0;
         assign base_q = '0;
      end
   endgenerate
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
   import cfgx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WIN_LOG2 = 28,
   parameter logic [ADDR_W-1:0] INDEX_ADDR = 'hCF8,
   parameter logic [ADDR_W-1:0] DATA_ADDR  = 'hCFC,
   localparam int BASE_W = ADDR_W - WIN_LOG2
) (
   input  logic              is_io,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] idx,
   input  logic              win_en,
   input  logic [BASE_W-1:0] win_base,
   output acc_kind_t         kind,
   output cfg_target_t       tgt
);
   logic io_index, io_data, mem_hit;

   assign io_index = is_io && (addr == INDEX_ADDR);
   assign io_data  = is_io && (addr == DATA_ADDR);
   assign mem_hit  = !is_io && win_en && (addr[ADDR_W-1:WIN_LOG2] == win_base);

   always_comb begin
      tgt  = '0;
      kind = K_MISS;
      if (io_index) begin
         kind = K_INDEX;
      end else if (io_data) begin
         if (idx[IX_EN]) kind = K_CFG;
         tgt.bus = idx[IX_BUS_LO +: BUS_W];
         tgt.dev = idx[IX_DEV_LO +: DEV_W];
         tgt.fn  = idx[IX_FN_LO  +: FN_W];
         tgt.rg  = {{(REG_W-IX_REG_W){1'b0}}, idx[IX_REG_LO +: IX_REG_W]};
      end else if (mem_hit) begin
         kind    = K_CFG;
         tgt.bus = addr[WN_BUS_LO +: BUS_W];
         tgt.dev = addr[WN_DEV_LO +: DEV_W];
         tgt.fn  = addr[WN_FN_LO  +: FN_W];
         tgt.rg  = addr[WN_REG_LO +: REG_W];
      end
   end
endmodule

// File: rtl/cfg_access_bridge.sv
module cfg_access_bridge
   import cfgx_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WIN_LOG2 = 28,
   parameter bit HAS_WINDOW = 1'b1,
   parameter logic [ADDR_W-1:0] INDEX_ADDR = 'hCF8,
   parameter logic [ADDR_W-1:0] DATA_ADDR  = 'hCFC,
   localparam int BASE_W = ADDR_W - WIN_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_set,
   input  logic              win_enable,
   input  logic [BASE_W-1:0] win_base,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_is_io,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] req_rdata,
   output logic              cfg_valid,
   input  logic              cfg_ready,
   output logic              cfg_write,
   output logic [BUS_W-1:0]  cfg_bus,
   output logic [DEV_W-1:0]  cfg_dev,
   output logic [FN_W-1:0]   cfg_fn,
   output logic [REG_W-1:0]  cfg_reg,
   output logic [DATA_W-1:0] cfg_wdata,
   input  logic [DATA_W-1:0] cfg_rdata
);
   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("cfg_access_bridge: DATA_W must be 32");
      end
      if (WIN_LOG2 < 2 + REG_W + FN_W + DEV_W + BUS_W) begin : g_bad_win
         $error("cfg_access_bridge: window too small for target fields");
      end
      if (WIN_LOG2 >= ADDR_W) begin : g_bad_addr
         $error("cfg_access_bridge: ADDR_W must exceed WIN_LOG2");
      end
   endgenerate

   bridge_state_t st_q;
   logic [DATA_W-1:0] idx_q, idx_view;
   logic              win_en_q;
   logic [BASE_W-1:0] win_base_q;
   acc_kind_t         kind;
   cfg_target_t       tgt, tgt_q;
   logic              accept, idx_wr;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;

   assign accept = (st_q == ST_IDLE) && req_valid;
   assign idx_wr = accept && (kind == K_INDEX) && req_write;

   cfgx_index_reg #(.DATA_W(DATA_W), .READ_MASK(IX_READ_MASK)) u_index (
      .clk(clk), .rst_n(rst_n), .wr_en(idx_wr), .wr_data(req_wdata),
      .idx_q(idx_q), .idx_view(idx_view)
   );

   cfgx_window_reg #(.BASE_W(BASE_W), .HAS_WINDOW(HAS_WINDOW)) u_window (
      .clk(clk), .rst_n(rst_n), .set(win_set), .enable_in(win_enable),
      .base_in(win_base), .en_q(win_en_q), .base_q(win_base_q)
   );

   cfgx_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LOG2(WIN_LOG2),
      .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
   ) u_decode (
      .is_io(req_is_io), .addr(req_addr), .idx(idx_q),
      .win_en(win_en_q), .win_base(win_base_q), .kind(kind), .tgt(tgt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         tgt_q   <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (req_valid) begin
               if (kind == K_CFG) begin
                  st_q    <= ST_ISSUE;
                  tgt_q   <= tgt;
                  wr_q    <= req_write;
                  wdata_q <= req_wdata;
               end else begin
                  st_q    <= ST_RESP;
                  rdata_q <= (kind == K_INDEX) ? idx_view : '1;
               end
            end
            ST_ISSUE: if (cfg_ready) begin
               st_q    <= ST_RESP;
               rdata_q <= wr_q ? '0 : cfg_rdata;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == ST_RESP);
   assign req_rdata = rdata_q;
   assign cfg_valid = (st_q == ST_ISSUE);
   assign cfg_write = wr_q;
   assign cfg_bus   = tgt_q.bus;
   assign cfg_dev   = tgt_q.dev;
   assign cfg_fn    = tgt_q.fn;
   assign cfg_reg   = tgt_q.rg;
   assign cfg_wdata = wdata_q;
endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker #(
   parameter logic [31:0] INDEX_ADDR = 32'hCF8,
   parameter logic [31:0] DATA_ADDR  = 32'hCFC
) (
   input logic        clk,
   input logic        rst_n,
   input logic        idle,
   input logic        req_valid,
   input logic        req_ready,
   input logic        req_is_io,
   input logic        req_write,
   input logic [31:0] req_addr,
   input logic        cfg_valid,
   input logic        cfg_ready,
   input logic [58:0] cfg_fields,
   input logic [31:0] idx_q,
   input logic        win_en_q
);
   // R1: index write never starts a configuration request
   p_index_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      idle && req_valid && req_is_io && req_write && req_addr == INDEX_ADDR |=> !cfg_valid);

   // R5: disabled index keeps the data port local
   p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      idle && req_valid && req_is_io && req_addr == DATA_ADDR && !idx_q[31] |=> !cfg_valid);

   // R3: a configuration request only starts from a host request
   p_cfg_from_host_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_valid) |-> $past(req_valid));

   // R8: request fields hold while waiting
   p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_fields));

   // R8: host completes the cycle after the downstream handshake
   p_done_after_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid && cfg_ready |=> req_ready && !cfg_valid);

   // R9: completion is a single-cycle pulse
   p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready);

   // R10: reset clears the index and window enable
   p_reset_state_r10: assert property (@(posedge clk)
      !rst_n |=> idx_q == 32'h0 && !win_en_q);
endmodule

bind cfg_access_bridge cfgx_checker #(
   .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
) u_cfgx_checker (
   .clk(clk), .rst_n(rst_n), .idle(st_q == cfgx_pkg::ST_IDLE),
   .req_valid(req_valid), .req_ready(req_ready), .req_is_io(req_is_io),
   .req_write(req_write), .req_addr(req_addr),
   .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
   .cfg_fields({cfg_write, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_wdata}),
   .idx_q(idx_q), .win_en_q(win_en_q)
);

// File: tb/test_cfg_access_bridge.sv
module test_cfg_access_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_set = 1'b0, win_enable = 1'b0;
   logic [3:0]  win_base = '0;
   logic        req_valid = 1'b0, req_is_io = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready;
   logic [31:0] req_rdata;
   logic        cfg_valid, cfg_write;
   logic        cfg_ready = 1'b0;
   logic [7:0]  cfg_bus;
   logic [4:0]  cfg_dev;
   logic [2:0]  cfg_fn;
   logic [9:0]  cfg_reg;
   logic [31:0] cfg_wdata, cfg_rdata = '0;

   int n_checks = 0, n_fail = 0;
   int cfg_count = 0, cfg_wait = 0, wait_cnt = 0;
   logic [7:0] l_bus; logic [4:0] l_dev; logic [2:0] l_fn; logic [9:0] l_reg;
   logic l_wr; logic [31:0] l_wdata;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfg_access_bridge i_cfg_access_bridge (.*);

   function automatic logic [31:0] resp_word(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [9:0] r);
      return {6'h2B, b, d, f, r};
   endfunction

   // downstream completion model
   initial forever begin
      @(negedge clk);
      if (cfg_ready) cfg_ready = 1'b0;
      else if (cfg_valid) begin
         if (wait_cnt >= cfg_wait) begin
            cfg_ready = 1'b1;
            cfg_rdata = resp_word(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
            l_bus = cfg_bus; l_dev = cfg_dev; l_fn = cfg_fn; l_reg = cfg_reg;
            l_wr = cfg_write; l_wdata = cfg_wdata;
            cfg_count++;
            wait_cnt = 0;
         end else wait_cnt++;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic host(bit io, bit wr, logic [31:0] a, logic [31:0] wd,
                       output logic [31:0] rd, output int lat, output int ncfg);
      int c0;
      c0 = cfg_count;
      @(negedge clk);
      req_valid = 1'b1; req_is_io = io; req_write = wr; req_addr = a; req_wdata = wd;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!req_ready && lat < 100);
      rd = req_rdata;
      req_valid = 1'b0;
      ncfg = cfg_count - c0;
   endtask

   task automatic program_window(bit en, logic [3:0] base);
      @(negedge clk);
      win_set = 1'b1; win_enable = en; win_base = base;
      @(negedge clk);
      win_set = 1'b0;
   endtask

   initial begin
      int ok_lat;
      ok_lat = 0;
      while (!done && ok_lat < 150000) begin @(posedge clk); ok_lat++; end
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", ok_lat, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd, idx;
      int lat, nc;
      logic [7:0] buses[4] = '{8'h00, 8'h01, 8'h5A, 8'hFF};
      logic [4:0] devs[3]  = '{5'd0, 5'd7, 5'd31};
      logic [2:0] fns[3]   = '{3'd0, 3'd5, 3'd7};
      logic [5:0] regs[3]  = '{6'd0, 6'd1, 6'h3F};
      logic [9:0] wregs[3] = '{10'd0, 10'h155, 10'h3FF};

      repeat (3) @(negedge clk);
      check("R10 req_ready in reset", {31'b0, req_ready}, 32'h0);
      check("R10 cfg_valid in reset", {31'b0, cfg_valid}, 32'h0);
      rst_n = 1'b1;

      host(1, 0, 32'hCF8, 0, rd, lat, nc);
      check("R10 index after reset", rd, 32'h0);
      check("R9 local latency", lat, 1);
      host(1, 0, 32'hCFC, 0, rd, lat, nc);
      check("R5 data read while disabled", rd, 32'hFFFF_FFFF);
      check("R5 no cfg while disabled", nc, 0);
      host(0, 0, 32'h0000_0000, 0, rd, lat, nc);
      check("R10 window off after reset", nc, 0);

      // index/data sweep
      for (int b = 0; b < 4; b++)
         for (int d = 0; d < 3; d++)
            for (int f = 0; f < 3; f++)
               for (int r = 0; r < 3; r++) begin
                  cfg_wait = (b + d + f + r) % 3;
                  idx = {1'b1, 7'h55, buses[b], devs[d], fns[f], regs[r], 2'b11};
                  host(1, 1, 32'hCF8, idx, rd, lat, nc);
                  check("R1 index write issues no cfg", nc, 0);
                  host(1, 0, 32'hCF8, 0, rd, lat, nc);
                  check("R2 index readback mask", rd, {1'b1, 7'h0, buses[b], devs[d], fns[f], regs[r], 2'b00});
                  host(1, 0, 32'hCFC, 0, rd, lat, nc);
                  check("R3 one cfg read", nc, 1);
                  check("R3 target fields", {l_wr, l_bus, l_dev, l_fn, l_reg},
                        {1'b0, buses[b], devs[d], fns[f], 4'b0, regs[r]});
                  check("R8 read data returned", rd, resp_word(buses[b], devs[d], fns[f], {4'b0, regs[r]}));
                  check("R8 cfg latency", lat, 2 + cfg_wait);
                  host(1, 1, 32'hCFC, 32'hC0DE_0000 + b*64 + d*16 + f*4 + r, rd, lat, nc);
                  check("R4 one cfg write", nc, 1);
                  check("R4 write fields", {l_wr, l_bus, l_dev, l_fn, l_reg},
                        {1'b1, buses[b], devs[d], fns[f], 4'b0, regs[r]});
                  check("R4 write data", l_wdata, 32'hC0DE_0000 + b*64 + d*16 + f*4 + r);
               end

      // enable bit clear again with other fields set
      host(1, 1, 32'hCF8, 32'h7FFF_FFFF, rd, lat, nc);
      host(1, 0, 32'hCFC, 0, rd, lat, nc);
      check("R5 read ones when bit31 clear", rd, 32'hFFFF_FFFF);
      check("R5 no cfg read", nc, 0);
      host(1, 1, 32'hCFC, 32'h1234_5678, rd, lat, nc);
      check("R5 write dropped", nc, 0);
      host(1, 0, 32'hCF8, 0, rd, lat, nc);
      check("R5 index unchanged by dropped write", rd, 32'h00FF_FFFC);

      // memory window sweep
      program_window(1, 4'hE);
      for (int b = 0; b < 4; b++)
         for (int d = 0; d < 3; d++)
            for (int f = 0; f < 3; f++)
               for (int r = 0; r < 3; r++) begin
                  logic [31:0] a;
                  cfg_wait = (b + r) % 3;
                  a = {4'hE, buses[b], devs[d], fns[f], wregs[r], 2'b00};
                  host(0, (r == 1), a, 32'hBEEF_0000 + r, rd, lat, nc);
                  check("R6 one window cfg", nc, 1);
                  check("R6 window fields", {l_wr, l_bus, l_dev, l_fn, l_reg},
                        {(r == 1), buses[b], devs[d], fns[f], wregs[r]});
                  if (r != 1) check("R6 window read data", rd, resp_word(buses[b], devs[d], fns[f], wregs[r]));
                  else        check("R6 window write data", l_wdata, 32'hBEEF_0000 + r);
                  check("R8 window latency", lat, 2 + cfg_wait);
                  host(0, 0, {4'hD, a[27:0]}, 0, rd, lat, nc);
                  check("R7 outside window no cfg", nc, 0);
                  check("R7 outside window read ones", rd, 32'hFFFF_FFFF);
               end
      host(1, 0, 32'hCF4, 0, rd, lat, nc);
      check("R7 other IO port read ones", rd, 32'hFFFF_FFFF);
      check("R7 other IO port no cfg", nc, 0);
      check("R9 miss latency", lat, 1);
      host(0, 0, 32'h0000_0CFC, 0, rd, lat, nc);
      check("R7 memory at data port address no cfg", nc, 0);
      program_window(0, 4'hE);
      host(0, 0, 32'hE000_0000, 0, rd, lat, nc);
      check("R7 disabled window no cfg", nc, 0);
      check("R7 disabled window read ones", rd, 32'hFFFF_FFFF);

      // reset mid-run clears state
      program_window(1, 4'h3);
      host(1, 1, 32'hCF8, 32'h8000_0100, rd, lat, nc);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      host(1, 0, 32'hCF8, 0, rd, lat, nc);
      check("R10 index cleared by reset", rd, 32'h0);
      host(0, 0, 32'h3000_0000, 0, rd, lat, nc);
      check("R10 window disabled by reset", nc, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule